// File: doc/BRIEF.md
# Sector Group Protect Sequencer

This block is a host-side controller that runs the in-system algorithm for locking or unlocking sector groups of an external flash device. On a one-cycle `start` it samples a mode and a target group. It raises a request for the high-voltage level on the flash reset line and waits a settling time. It then issues single-cycle bus writes and reads that pulse the device, wait out the programmed pulse width, and read the lock state back. A failed readback triggers another pulse until an attempt limit is reached. It ends with one cycle on `done` or on `fail`.

Unlocking needs every group to be locked first. In unprotect mode the sequencer therefore walks all groups in order and locks any that read back unlocked. Only then does it issue an unlock pulse and check each group in turn. A third mode only holds the high-voltage request for temporary unlocking by other logic, and issues no bus cycles. All delays are counted in clock cycles, derived from a clock-rate parameter and microsecond parameters.

Top module: `grp_protect_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `fail`, `hv_req`, `bus_wr` and `bus_rd` are all low.
- R2: `start` is only taken while the block is idle. A `start` seen while `busy` is high has no effect on the running sequence or its outcome.
- R3: `hv_req` rises when a protect or unprotect run is taken. No bus cycle is issued until at least SETTLE_US×CLK_MHZ cycles after that rise.
- R4: A lock pulse writes data 0x60 to address {group, 7'b0000010}. The next write, 0x40 to the same address, comes at least PROT_US×CLK_MHZ cycles later.
- R5: A lock check writes 0x40 and then reads the same address. Read data 0x01 passes. Any other value gives another lock pulse. After PROT_TRIES pulses on one group have all failed, the run ends in `fail`.
- R6: In unprotect mode (`mode`=2'b01), groups 0 to 2^GW−1 are checked in order with the lock pattern. Each group that does not read 0x01 is locked by the R4/R5 procedure before any unlock pulse is issued.
- R7: An unlock pulse writes 0x60 to address {group, 7'b1000010}. The next write comes at least UNPROT_US×CLK_MHZ cycles later.
- R8: Unlock checks visit every group in ascending order and expect read data 0x00. A group that fails gets another unlock pulse and is checked again. After UNPROT_TRIES unlock pulses in total without success, the run ends in `fail`.
- R9: Every run in mode 2'b00 or 2'b01 ends in this order: `hv_req` drops, then 0xF0 is written to address 0, then exactly one of `done`/`fail` pulses for a single cycle. No write other than that 0xF0 occurs while `hv_req` is low.
- R10: In mode 2'b1x (temporary unlock), `hv_req` rises and stays high with `busy` low and no bus cycles. The next `start` drops `hv_req` and pulses `done`, with no 0xF0 write.
- R11: Mode 2'b00 locks only the group given on `grp_addr`, which is sampled with `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request |
| mode | input | 2 | 00 lock one group, 01 unlock all, 1x temporary unlock hold |
| grp_addr | input | GW | Target group for mode 00 |
| busy | output | 1 | A timed sequence is running |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| hv_req | output | 1 | Request for high voltage on the flash reset line |
| bus_wr | output | 1 | One-cycle flash write strobe |
| bus_rd | output | 1 | One-cycle flash read strobe; data is returned on the next cycle |
| bus_addr | output | GW+7 | Flash address: group in the upper bits, pattern in the low 7 |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data, registered by the device |

## Verification
On every cycle, the assertions check these properties:
- Only the final 0xF0 write may occur without the high-voltage request.
- `done` and `fail` are exclusive single-cycle pulses issued when not busy.
- The temporary hold produces no bus traffic.
- The attempt counter never steps past its limit.

A flash model in the bench needs a chosen number of pulses per group. The bench scenarios are the only way to show several things: the pulse widths and settle time as cycle gaps, the address patterns, the lock-before-unlock ordering, the exact pulse counts including both retry limits, and that a `start` during a run changes nothing.

// File: rtl/grp_seq_pkg.sv
package grp_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE, S_PULSE, S_PWAIT, S_VWR, S_VRD, S_VWT, S_VCHK,
    S_HVOFF, S_RSTWR, S_END, S_HOLD
  } seq_st_e;

  typedef enum logic [1:0] {PH_PROT, PH_PRE, PH_UNP} seq_ph_e;

  localparam logic [7:0] CMD_PULSE  = 8'h60;
  localparam logic [7:0] CMD_VERIFY = 8'h40;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [6:0] PAT_LOCK   = 7'b0000010;
  localparam logic [6:0] PAT_UNLOCK = 7'b1000010;
  localparam logic [7:0] OK_LOCK    = 8'h01;
  localparam logic [7:0] OK_UNLOCK  = 8'h00;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3
  expiry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);
endmodule

// File: rtl/seq_attempts.sv
module seq_attempts #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         at_limit
);
  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign at_limit = (count == limit);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |-> !at_limit);
endmodule

// File: rtl/grp_protect_seq.sv
module grp_protect_seq
  import grp_seq_pkg::*;
#(
  parameter int GW           = 3,
  parameter int CLK_MHZ      = 50,
  parameter int SETTLE_US    = 1,
  parameter int PROT_US      = 150,
  parameter int UNPROT_US    = 15000,
  parameter int PROT_TRIES   = 25,
  parameter int UNPROT_TRIES = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [GW-1:0]   grp_addr,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic            hv_req,
  output logic            bus_wr,
  output logic            bus_rd,
  output logic [GW+6:0]   bus_addr,
  output logic [7:0]      bus_wdata,
  input  logic [7:0]      bus_rdata
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int PROT_CYC   = CLK_MHZ * PROT_US;
  localparam int UNP_CYC    = CLK_MHZ * UNPROT_US;
  localparam int MAXD1      = (UNP_CYC > PROT_CYC) ? UNP_CYC : PROT_CYC;
  localparam int MAXD       = (MAXD1 > SETTLE_CYC) ? MAXD1 : SETTLE_CYC;
  localparam int TW         = $clog2(MAXD + 1);
  localparam int MAXT       = (UNPROT_TRIES > PROT_TRIES) ? UNPROT_TRIES : PROT_TRIES;
  localparam int CW         = $clog2(MAXT + 1);

  seq_st_e         st;
  seq_ph_e         ph;
  logic [GW-1:0]   grp;
  logic            ok, tmp;
  logic            tmr_load, tmr_exp, att_clr, att_inc, at_limit, rd_pass;
  logic [TW-1:0]   tmr_val;
  logic [CW-1:0]   att_limit;
  logic [6:0]      pat;

  assign pat       = (ph == PH_UNP) ? PAT_UNLOCK : PAT_LOCK;
  assign rd_pass   = (bus_rdata == ((ph == PH_UNP) ? OK_UNLOCK : OK_LOCK));
  assign att_limit = (ph == PH_UNP) ? CW'(UNPROT_TRIES) : CW'(PROT_TRIES);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    att_clr  = 1'b0;
    att_inc  = 1'b0;
    case (st)
      S_IDLE:  if (start) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(SETTLE_CYC);
        att_clr  = 1'b1;
      end
      S_PULSE: begin
        tmr_load = 1'b1;
        tmr_val  = (ph == PH_UNP) ? TW'(UNP_CYC) : TW'(PROT_CYC);
        att_inc  = 1'b1;
      end
      S_VCHK:  if (rd_pass && ph == PH_PRE) att_clr = 1'b1;
      default: ;
    endcase
  end

  seq_timer #(.W(TW)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
  );

  seq_attempts #(.W(CW)) att_i (
    .clk(clk), .rst(rst), .clr(att_clr), .inc(att_inc),
    .limit(att_limit), .at_limit(at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  ph <= PH_PROT;  grp <= '0;  ok <= 1'b0;  tmp <= 1'b0;
      busy <= 1'b0;  done <= 1'b0;  fail <= 1'b0;  hv_req <= 1'b0;
      bus_wr <= 1'b0;  bus_rd <= 1'b0;  bus_addr <= '0;  bus_wdata <= '0;
    end else begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          hv_req <= 1'b1;
          busy   <= 1'b1;
          tmp    <= mode[1];
          ph     <= mode[0] ? PH_PRE : PH_PROT;
          grp    <= mode[0] ? '0 : grp_addr;
          st     <= S_SETTLE;
        end
        S_SETTLE: if (tmr_exp) begin
          if (tmp) begin
            busy <= 1'b0;
            st   <= S_HOLD;
          end else begin
            st <= (ph == PH_PRE) ? S_VWR : S_PULSE;
          end
        end
        S_PULSE: begin
          bus_wr    <= 1'b1;
          bus_addr  <= {grp, pat};
          bus_wdata <= CMD_PULSE;
          st        <= S_PWAIT;
        end
        S_PWAIT: if (tmr_exp) st <= S_VWR;
        S_VWR: begin
          bus_wr    <= 1'b1;
          bus_addr  <= {grp, pat};
          bus_wdata <= CMD_VERIFY;
          st        <= S_VRD;
        end
        S_VRD: begin
          bus_rd <= 1'b1;
          st     <= S_VWT;
        end
        S_VWT: st <= S_VCHK;
        S_VCHK: begin
          if (rd_pass) begin
            case (ph)
              PH_PROT: begin ok <= 1'b1; st <= S_HVOFF; end
              PH_PRE: begin
                grp <= grp + 1'b1;
                if (&grp) begin ph <= PH_UNP; st <= S_PULSE; end
                else      st <= S_VWR;
              end
              default: begin
                grp <= grp + 1'b1;
                if (&grp) begin ok <= 1'b1; st <= S_HVOFF; end
                else      st <= S_VWR;
              end
            endcase
          end else if (at_limit) begin
            ok <= 1'b0;
            st <= S_HVOFF;
          end else begin
            st <= S_PULSE;
          end
        end
        S_HVOFF: begin
          hv_req <= 1'b0;
          st     <= S_RSTWR;
        end
        S_RSTWR: begin
          bus_wr    <= 1'b1;
          bus_addr  <= '0;
          bus_wdata <= CMD_RESET;
          st        <= S_END;
        end
        S_END: begin
          done <= ok;
          fail <= !ok;
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        S_HOLD: if (start) begin
          hv_req <= 1'b0;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  low_hv_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hv_req) |-> (bus_wdata == CMD_RESET && bus_addr == '0));
  // R9
  result_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |=> !(done || fail));
  // R2
  result_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy);
  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (hv_req && !busy) |-> (!bus_wr && !bus_rd));
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
endmodule

// File: tb/grp_protect_seq_tb.sv
module grp_protect_seq_tb_top;
  localparam int GW = 3;
  localparam int NG = 1 << GW;
  localparam int AW = GW + 7;
  localparam int SET_C = 2;
  localparam int PROT_C = 20;
  localparam int UNP_C = 40;
  localparam int PT = 25;
  localparam int UT = 1000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [GW-1:0] grp_addr = '0;
  logic busy, done, fail, hv_req, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  grp_protect_seq #(.GW(GW), .CLK_MHZ(2), .SETTLE_US(1), .PROT_US(10),
                    .UNPROT_US(20), .PROT_TRIES(PT), .UNPROT_TRIES(UT)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .grp_addr(grp_addr),
    .busy(busy), .done(done), .fail(fail), .hv_req(hv_req), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int vectors = 0, errors = 0, cyc = 0;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    vectors++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash model
  bit prot[NG];
  int need_p[NG], pcnt[NG];
  int need_u, ucnt;
  always @(posedge clk) begin
    bus_rdata <= 8'h00;
    if (bus_wr && hv_req && bus_wdata == 8'h60) begin
      if (!bus_addr[6]) begin
        pcnt[bus_addr[AW-1:7]]++;
        if (pcnt[bus_addr[AW-1:7]] >= need_p[bus_addr[AW-1:7]]) prot[bus_addr[AW-1:7]] = 1'b1;
      end else begin
        ucnt++;
        if (ucnt >= need_u) for (int g = 0; g < NG; g++) prot[g] = 1'b0;
      end
    end
    if (bus_rd && hv_req) bus_rdata <= prot[bus_addr[AW-1:7]] ? 8'h01 : 8'h00;
  end

  // bus monitor
  int n_pp = 0, n_up = 0, n_f0 = 0, n_bus = 0, t_hv = 0, t60 = 0;
  bit hv_d = 0, first_seen = 0, seen_unp = 0, have60 = 0, last60_unp = 0;
  logic [AW-1:0] a60, a40;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (hv_req && !hv_d) begin t_hv = cyc; first_seen = 0; seen_unp = 0; have60 = 0; end
      hv_d = hv_req;
      if (bus_wr || bus_rd) begin
        n_bus++;
        if (hv_req && !first_seen) begin
          first_seen = 1;
          chk(cyc - t_hv >= SET_C, "R3 settle gap", cyc - t_hv, SET_C);
        end
      end
      if (bus_wr && bus_wdata == 8'h60) begin
        if (!bus_addr[6]) begin
          n_pp++;
          chk(bus_addr[6:0] == 7'b0000010, "R4 lock pattern", bus_addr[6:0], 2);
          chk(!seen_unp, "R6 lock after unlock", 1, 0);
        end else begin
          n_up++;
          seen_unp = 1;
          chk(bus_addr[6:0] == 7'b1000010, "R7 unlock pattern", bus_addr[6:0], 66);
        end
        have60 = 1; t60 = cyc; a60 = bus_addr; last60_unp = bus_addr[6];
      end
      if (bus_wr && bus_wdata == 8'h40) begin
        a40 = bus_addr;
        if (have60) begin
          have60 = 0;
          chk(bus_addr == a60, "R4 verify address", bus_addr, a60);
          chk(cyc - t60 >= (last60_unp ? UNP_C : PROT_C), last60_unp ? "R7 pulse width" : "R4 pulse width",
              cyc - t60, last60_unp ? UNP_C : PROT_C);
        end
      end
      if (bus_rd) chk(bus_addr == a40, "R5 read address", bus_addr, a40);
      if (bus_wr && bus_wdata == 8'hF0) begin
        n_f0++;
        chk(!hv_req && bus_addr == '0, "R9 reset write", bus_addr, 0);
      end
      if (bus_wr && !hv_req && bus_wdata != 8'hF0) chk(0, "R9 write without hv", bus_wdata, 8'hF0);
    end
  end

  initial begin
    while (cyc < 190000) @(negedge clk);
    chk(0, "watchdog", cyc, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // expected lock pulses for mode 00 on group g
  function automatic int exp_lock_pulses(input int g);
    return prot[g] ? 1 : min_i(need_p[g], PT);
  endfunction

  task automatic pulse_start(input logic [1:0] m, input int g);
    @(negedge clk);
    mode = m; grp_addr = GW'(g); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [1:0] m, input int g, input bit poke);
    int e_pp, e_up, b_pp, b_up, b_f0, pc0;
    bit e_ok, got_done, got_fail, stop;
    e_pp = 0; e_up = 0; e_ok = 1; stop = 0;
    if (m == 2'b00) begin
      e_pp = exp_lock_pulses(g);
      e_ok = prot[g] || need_p[g] <= PT;
    end else begin
      for (int k = 0; k < NG; k++) if (!stop && !prot[k]) begin
        e_pp += min_i(need_p[k], PT);
        if (need_p[k] > PT) begin e_ok = 0; stop = 1; end
      end
      if (!stop) begin e_up = min_i(need_u, UT); e_ok = need_u <= UT; end
    end
    for (int k = 0; k < NG; k++) pcnt[k] = 0;
    ucnt = 0;
    b_pp = n_pp; b_up = n_up; b_f0 = n_f0; pc0 = 0;
    pulse_start(m, g);
    chk(busy && hv_req, "R3 hv_req with busy", {busy, hv_req}, 3);
    if (poke) begin
      repeat (8) @(negedge clk);
      pulse_start(~m, g ^ 1);
    end
    while (!(done || fail)) @(negedge clk);
    got_done = done; got_fail = fail;
    chk(got_done == e_ok && got_fail == !e_ok, m[0] ? "R8 outcome" : "R5 outcome", got_done, e_ok);
    chk(n_pp - b_pp == e_pp, m[0] ? "R6 lock pulse count" : "R5 lock pulse count", n_pp - b_pp, e_pp);
    chk(n_up - b_up == e_up, "R8 unlock pulse count", n_up - b_up, e_up);
    chk(n_f0 - b_f0 == 1, "R9 one reset write", n_f0 - b_f0, 1);
    if (m == 2'b00) begin
      chk(pcnt[g] == e_pp, "R11 pulses on target group", pcnt[g], e_pp);
      if (e_ok) chk(prot[g], "R11 target locked", prot[g], 1);
    end else if (e_ok) begin
      for (int k = 0; k < NG; k++) pc0 += prot[k];
      chk(pc0 == 0, "R8 all unlocked", pc0, 0);
    end
    @(negedge clk);
    chk(!done && !fail && !hv_req && !busy, "R9 single pulse and idle", {done, fail, hv_req, busy}, 0);
  endtask

  int r, b0;
  initial begin
    for (int k = 0; k < NG; k++) begin prot[k] = 0; need_p[k] = 1; pcnt[k] = 0; end
    need_u = 1; ucnt = 0;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({busy, done, fail, hv_req, bus_wr, bus_rd} == 6'b0, "R1 reset outputs",
        {busy, done, fail, hv_req, bus_wr, bus_rd}, 0);

    // directed: lock with two retries
    need_p[5] = 3;
    run(2'b00, 5, 0);
    // directed: start while busy is ignored
    prot[2] = 0; need_p[2] = 2;
    run(2'b00, 2, 1);
    // directed: lock retry limit
    prot[6] = 0; need_p[6] = PT + 5;
    run(2'b00, 6, 0);
    // random runs
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < NG; k++) begin
        prot[k] = $urandom_range(0, 1);
        need_p[k] = $urandom_range(1, 4);
      end
      need_u = $urandom_range(1, 3);
      run({1'b0, 1'($urandom_range(0, 1))}, $urandom_range(0, NG - 1), 0);
    end
    // directed: unlock with one group needing lock first, three unlock pulses
    for (int k = 0; k < NG; k++) begin prot[k] = 1; need_p[k] = 1; end
    prot[NG-1] = 0; need_p[NG-1] = 2; need_u = 3;
    run(2'b01, 0, 0);
    // directed: pre-lock fails on group 3
    for (int k = 0; k < NG; k++) prot[k] = 1;
    prot[3] = 0; need_p[3] = PT + 1;
    run(2'b01, 0, 0);
    // directed: unlock retry limit
    for (int k = 0; k < NG; k++) begin prot[k] = 1; need_p[k] = 1; end
    need_u = UT + 1;
    run(2'b01, 0, 0);
    // temporary unlock hold
    b0 = n_bus;
    pulse_start(2'b10, 0);
    repeat (60) @(negedge clk);
    chk(hv_req && !busy, "R10 hold state", {hv_req, busy}, 2);
    chk(n_bus == b0, "R10 no bus cycles", n_bus - b0, 0);
    pulse_start(2'b00, 0);
    r = 0;
    for (int k = 0; k < 4 && !done; k++) @(negedge clk);
    chk(done && !hv_req, "R10 release", {done, hv_req}, 2);
    repeat (4) @(negedge clk);
    chk(n_bus == b0 && !busy, "R10 no reset write", n_bus - b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule